// File: doc/BRIEF.md
# Boundary-Scan Test Access Port with Instruction and Data Chains

This block is a test access port that runs entirely on the test clock `tck`. A sixteen-state controller follows the `tms` value sampled on each rising `tck` edge. That controller decides when a serial chain captures parallel data, when it shifts from `tdi` toward `tdo`, and when its parallel holding stage is updated. The current state also decides whether the instruction chain or a data chain is in use.

There is one 4-bit instruction chain with a holding stage. The instruction in that holding stage picks one of three data chains: a 1-bit bypass chain, a 32-bit identification chain, and a generic user chain of configurable width that has its own holding stage. Two test opcodes select no chain at all, so every chain keeps its contents while they are active. Any opcode that is not implemented behaves as bypass, so `tdi` always has a serial path to `tdo`.

The serial data has no valid/ready handshake. One bit moves per `tck` cycle while the controller is in a shift state. Back-pressure is applied by holding `tck` or by parking the controller in a pause state. The controller is reset asynchronously by `trst_n`, which is active low.

Top module: `scan_tap`

## Requirements
- R1: While `trst_n` is low, the controller is held in Test-Logic-Reset, `tdo_oe` is 0, and the instruction holding stage holds IDCODE (binary 0010). This applies whenever `trst_n` goes low, including in the middle of a scan.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state. Entering Test-Logic-Reset reloads IDCODE as the current instruction.
- R3: In Capture-IR the instruction chain loads binary 0001. During Shift-IR it shifts out least significant bit first, so the first bit out is 1 and the next three bits are 0.
- R4: With IDCODE active, Capture-DR loads the 32-bit parameter `IDCODE_VAL`, whose bit 0 is 1, and Shift-DR returns it least significant bit first.
- R5: With BYPASS active (binary 1111), the data path is a single stage that captures 0. Its first output bit is 0, and after that `tdo` repeats `tdi` one shift cycle later.
- R6: Every opcode other than 0000, 0010, 0100, 1000 and 1111 behaves exactly like BYPASS.
- R7: With USER active (binary 1000), a `USER_W`-bit chain captures its holding stage in Capture-DR, shifts least significant bit first, and loads its holding stage from the shifted-in value in Update-DR.
- R8: With EXTEST (0000) or INTEST (0100) active, no data chain captures, shifts or updates. `tdo` reads 0 during Shift-DR, and the user holding stage keeps its value.
- R9: `tdo` and `tdo_oe` change only on the falling edge of `tck`. `tdo_oe` is 1 only while the controller is in Shift-IR or Shift-DR.
- R10: The state moves only on rising `tck` edges and follows the standard sixteen-state graph. This includes leaving a shift through Exit1 and Pause and returning to it through Exit2 in the middle of a scan.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on the rising edge of `tck` |
| tdi | input | 1 | Serial data in, sampled on the rising edge of `tck` |
| tdo | output | 1 | Serial data out, updated on the falling edge of `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` (1 while shifting) |

## Verification
The hardest case to provoke from the pins is showing that EXTEST or INTEST left a chain alone. Nothing can be seen while those opcodes are active, so the bench first writes a known pattern into the user chain. It then runs a full data scan under the test opcode and switches back to USER to read the pattern out intact. Reaching Test-Logic-Reset from deep states is also awkward. The bench parks the controller in Pause-DR or Pause-IR, then applies five `tms`-high edges or a mid-cycle `trst_n` pulse, and confirms recovery by reading the identification value.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int unsigned IR_W = 4;

  localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
  localparam logic [IR_W-1:0] OP_IDCODE = 4'b0010;
  localparam logic [IR_W-1:0] OP_INTEST = 4'b0100;
  localparam logic [IR_W-1:0] OP_USER   = 4'b1000;
  localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_USER, SEL_NONE} dr_sel_e;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    unique case (s)
      ST_TLR:    return m ? ST_TLR    : ST_RTI;
      ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return m ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: return m ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return m ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return m ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: return m ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return m ? ST_UPD_IR : ST_SHF_IR;
      default:   return m ? ST_SEL_DR : ST_RTI;
    endcase
  endfunction

  function automatic dr_sel_e decode_op(input logic [IR_W-1:0] op);
    unique case (op)
      OP_EXTEST, OP_INTEST: return SEL_NONE;
      OP_IDCODE:            return SEL_ID;
      OP_USER:              return SEL_USER;
      default:              return SEL_BYP;
    endcase
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state,
  output tap_state_e state_nxt
);

  always_comb state_nxt = tap_next(state, tms);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_TLR;
    else         state <= state_nxt;
  end

  // R2
  tlr_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR && tms) |=> (state == ST_TLR));

  // R10
  upd_to_idle_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_UPD_IR && !tms) |=> (state == ST_RTI));

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  tap_state_e      state,
  input  tap_state_e      state_nxt,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_so
);

  logic [IR_W-1:0] ir_sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_sr <= IR_CAPTURE;
    end else if (state == ST_CAP_IR) begin
      ir_sr <= IR_CAPTURE;
    end else if (state == ST_SHF_IR) begin
      ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_q <= OP_IDCODE;
    end else if (state_nxt == ST_TLR) begin
      ir_q <= OP_IDCODE;
    end else if (state == ST_UPD_IR) begin
      ir_q <= ir_sr;
    end
  end

  assign ir_so = ir_sr[0];

  // R2
  tlr_idcode_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR) |-> (ir_q == OP_IDCODE));

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter int unsigned USER_W     = 8,
  parameter logic [31:0] IDCODE_VAL = 32'h1A5C_E0D3
) (
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tdi,
  input  tap_state_e state,
  input  dr_sel_e    sel,
  output logic       dr_so
);

  logic              byp_q;
  logic [31:0]       id_sr;
  logic [USER_W-1:0] usr_sr;
  logic [USER_W-1:0] usr_hold;

  logic cap, shf, upd;
  always_comb begin
    cap = (state == ST_CAP_DR);
    shf = (state == ST_SHF_DR);
    upd = (state == ST_UPD_DR);
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                      byp_q <= 1'b0;
    else if (sel == SEL_BYP && cap)   byp_q <= 1'b0;
    else if (sel == SEL_BYP && shf)   byp_q <= tdi;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                      id_sr <= IDCODE_VAL;
    else if (sel == SEL_ID && cap)    id_sr <= IDCODE_VAL;
    else if (sel == SEL_ID && shf)    id_sr <= {tdi, id_sr[31:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                      usr_sr <= '0;
    else if (sel == SEL_USER && cap)  usr_sr <= usr_hold;
    else if (sel == SEL_USER && shf)  usr_sr <= {tdi, usr_sr[USER_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                      usr_hold <= '0;
    else if (sel == SEL_USER && upd)  usr_hold <= usr_sr;
  end

  always_comb begin
    unique case (sel)
      SEL_BYP:  dr_so = byp_q;
      SEL_ID:   dr_so = id_sr[0];
      SEL_USER: dr_so = usr_sr[0];
      default:  dr_so = 1'b0;
    endcase
  end

  // R8
  test_op_keep_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (sel == SEL_NONE && (shf || cap || upd)) |=> ($stable(usr_sr) && $stable(usr_hold) && $stable(id_sr)));

  // R5
  byp_cap_zero_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (sel == SEL_BYP && cap) |=> (byp_q == 1'b0));

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int unsigned USER_W     = 8,
  parameter logic [31:0] IDCODE_VAL = 32'h1A5C_E0D3
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  output logic tdo,
  output logic tdo_oe
);

  tap_state_e      state, state_nxt;
  logic [IR_W-1:0] ir_q;
  logic            ir_so, dr_so;
  dr_sel_e         sel;

  scan_tap_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(state), .state_nxt(state_nxt)
  );

  scan_tap_ir u_ir (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .state_nxt(state_nxt),
    .ir_q(ir_q), .ir_so(ir_so)
  );

  always_comb sel = decode_op(ir_q);

  scan_tap_dr #(.USER_W(USER_W), .IDCODE_VAL(IDCODE_VAL)) u_dr (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .state(state), .sel(sel), .dr_so(dr_so)
  );

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (state == ST_SHF_IR) || (state == ST_SHF_DR);
      tdo    <= (state == ST_SHF_IR) ? ir_so : dr_so;
    end
  end

  // R9
  oe_in_shift_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (state == ST_SHF_IR || state == ST_SHF_DR));

  // R1
  oe_off_in_tlr_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_TLR) |-> !tdo_oe);

endmodule

// File: tb/scan_tap_tb_top.sv
module scan_tap_tb_top;

  localparam int unsigned USER_W = 8;
  localparam logic [31:0] IDV    = 32'h1A5C_E0D3;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic tdo, tdo_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  bit    exp_q[$];
  string req_q[$];

  always #5 tck = ~tck;

  scan_tap #(.USER_W(USER_W), .IDCODE_VAL(IDV)) dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: pops one expected bit per shift cycle
  always @(negedge tck) begin
    #2;
    if (tdo_oe) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9", "tdo_oe high with nothing expected", 64'(tdo_oe), 64'd0);
      end else begin
        automatic bit e = exp_q.pop_front();
        automatic string r = req_q.pop_front();
        chk(tdo === e, r, "serial bit", 64'(tdo), 64'(e));
      end
    end
  end

  task automatic step(input bit m, input bit d);
    @(negedge tck);
    #1;
    tms = m;
    tdi = d;
    @(posedge tck);
  endtask

  task automatic push_exp(input int n, input logic [63:0] e, input string req);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(e[i]);
      req_q.push_back(req);
    end
  endtask

  // full scan from Run-Test/Idle back to Run-Test/Idle
  task automatic scan(input bit ir, input int n, input logic [63:0] din,
                      input logic [63:0] dexp, input string req);
    push_exp(n, dexp, req);
    step(1, 0);
    if (ir) step(1, 0);
    step(0, 0);
    step(0, 0);
    for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
    step(1, 0);
    step(0, 0);
    chk(exp_q.size() == 0, req, "all expected bits seen", 64'(exp_q.size()), 64'd0);
  endtask

  task automatic oe_low(input string req);
    @(negedge tck);
    #3;
    chk(tdo_oe == 1'b0, req, "tdo_oe low outside shift", 64'(tdo_oe), 64'd0);
  endtask

  task automatic to_pause_dr();
    step(1, 0); step(0, 0); step(1, 0); step(0, 0);
  endtask

  initial begin
    repeat (3) @(posedge tck);
    oe_low("R1");
    @(negedge tck);
    trst_n = 1'b1;
    step(0, 0);
    oe_low("R9");

    // R1/R4: IDCODE selected after reset
    scan(0, 32, 64'h0, 64'(IDV), "R4");

    // R3: capture 0001, load USER
    scan(1, 4, 64'(4'b1000), 64'(4'b0001), "R3");
    // R7: write then read back
    scan(0, USER_W, 64'hA5, 64'h00, "R7");
    scan(0, USER_W, 64'h3C, 64'hA5, "R7");

    // R8: EXTEST leaves user contents alone
    scan(1, 4, 64'(4'b0000), 64'(4'b0001), "R3");
    scan(0, USER_W, 64'hFF, 64'h00, "R8");
    scan(1, 4, 64'(4'b1000), 64'(4'b0001), "R3");
    scan(0, USER_W, 64'h00, 64'h3C, "R8");
    scan(0, USER_W, 64'h5A, 64'h00, "R7");
    // R8: INTEST
    scan(1, 4, 64'(4'b0100), 64'(4'b0001), "R3");
    scan(0, USER_W, 64'h0F, 64'h00, "R8");
    scan(1, 4, 64'(4'b1000), 64'(4'b0001), "R3");
    scan(0, USER_W, 64'h11, 64'h5A, "R8");

    // R5: BYPASS
    scan(1, 4, 64'(4'b1111), 64'(4'b0001), "R3");
    scan(0, 8, 64'hB2, {56'h0, 8'hB2 << 1}, "R5");

    // R6: unimplemented opcodes
    scan(1, 4, 64'(4'b0110), 64'(4'b0001), "R3");
    scan(0, 8, 64'h4D, {56'h0, 8'h4D << 1}, "R6");
    scan(1, 4, 64'(4'b1010), 64'(4'b0001), "R3");
    scan(0, 8, 64'hE1, {56'h0, 8'hE1 << 1}, "R6");

    // R10: IR scan interrupted by Pause-IR, loads USER
    push_exp(4, 64'(4'b0001), "R10");
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    step(0, 0); step(1, 0);
    step(0, 0); step(0, 0);
    oe_low("R10");
    step(1, 0); step(0, 0);
    step(0, 0); step(1, 1);
    step(1, 0); step(0, 0);
    chk(exp_q.size() == 0, "R10", "paused IR scan complete", 64'(exp_q.size()), 64'd0);
    scan(0, USER_W, 64'h77, 64'h11, "R10");

    // R2: five TMS-high edges from Pause-DR
    to_pause_dr();
    oe_low("R9");
    repeat (5) step(1, 0);
    step(0, 0);
    scan(0, 32, 64'h0, 64'(IDV), "R2");

    // R2: from Pause-IR with USER loaded
    scan(1, 4, 64'(4'b1000), 64'(4'b0001), "R3");
    step(1, 0); step(1, 0); step(0, 0); step(1, 0); step(0, 0);
    repeat (5) step(1, 0);
    step(0, 0);
    scan(0, 32, 64'h0, 64'(IDV), "R2");

    // R1: asynchronous reset mid-scan
    scan(1, 4, 64'(4'b1000), 64'(4'b0001), "R3");
    to_pause_dr();
    @(negedge tck);
    #3;
    trst_n = 1'b0;
    #1;
    chk(tdo_oe == 1'b0, "R1", "tdo_oe low during reset", 64'(tdo_oe), 64'd0);
    @(negedge tck);
    #1;
    tms = 1'b0;
    trst_n = 1'b1;
    @(posedge tck);
    scan(0, 32, 64'h0, 64'(IDV), "R1");
    // user hold was reset to zero
    scan(1, 4, 64'(4'b1000), 64'(4'b0001), "R3");
    scan(0, USER_W, 64'h00, 64'h00, "R1");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule